// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the clocks of a serial audio link: the bit clock, a transmit frame clock and a receive frame clock. It also produces two single-cycle strobes that tell a serializer where each bit begins and where its middle edge lies. It runs on the master audio clock. As the link master, it divides that clock down to the bit clock. It then counts bit clocks to form two frame clocks whose lengths are set independently. As the link slave, it brings in the bit and frame clocks from outside through a short synchronizer and derives the same strobes from the external bit-clock edges.

Every ratio is programmed as its value minus one. The bit-clock ratio N is the divider field plus one, and a frame of L bits has the length field L-1. A field of 0 for the bit divider makes the bit clock follow the master clock itself. The bit clock can be inverted for links that sample on the other edge. A new divider or frame length never cuts a clock period short. The bit ratio and the transmit length switch over together at the next transmit frame start. The receive length switches at the next receive frame start.

A typical setting uses a master clock at 256 times the sample rate and 64 bits per frame. That is a bit-divider field of 3 and a frame-length field of 63.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst` is high, `bclk_out`, `tx_fs`, `rx_fs`, `bit_lead_stb` and `bit_trail_stb` are 0 (polarity 0, master mode, divider field not 0). The first master-clock cycle after release is bit 0 of frame 0: `bit_lead_stb` is 1 and `bclk_out` is 1.
- R2: In master mode with divider field D ≥ 1 (N = D+1), the non-inverted bit clock is high for ceil(N/2) master cycles and low for floor(N/2) master cycles. For odd N, the extra cycle goes to the high phase.
- R3: `bit_lead_stb` is 1 for exactly the first master cycle of each bit-clock high phase (non-inverted sense). `bit_trail_stb` is 1 for exactly the first cycle of each low phase.
- R4: With transmit length field T (L = T+1 bits per frame), `tx_fs` is 0 during bits 0 to floor(L/2)-1 of a frame and 1 during the remaining bits. It changes only in a cycle where `bit_lead_stb` is 1.
- R5: `rx_fs` follows the same rule as R4 with its own field `rx_len_m1`. It runs independently of the transmit length.
- R6: With `bclk_inv` = 1, `bclk_out` is the complement of the clock described in R2. The strobes keep their meaning, so `bclk_out` is 0 in a cycle where `bit_lead_stb` is 1.
- R7: With `slave_sel` = 1, `bclk_out`, `tx_fs` and `rx_fs` equal `ext_bclk`, `ext_tx_fs` and `ext_rx_fs` delayed by two master cycles. `bit_lead_stb` marks the cycle where the delayed bit clock goes from 0 to 1, and `bit_trail_stb` marks the cycle where it goes from 1 to 0.
- R8: In master mode with divider field 0, `bclk_out` equals `clk` (or its complement with `bclk_inv` = 1), and both strobes are 1 in every cycle.
- R9: A new `bclk_div_m1` or `tx_len_m1` value takes effect at the next transmit frame start. A new `rx_len_m1` value takes effect at the next receive frame start. Bits still in the current frame keep the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_sel | input | 1 | 0 = generate clocks, 1 = take external clocks |
| bclk_inv | input | 1 | 1 = invert the bit-clock output |
| bclk_div_m1 | input | DIV_W | Master-to-bit-clock ratio minus one |
| tx_len_m1 | input | LEN_W | Transmit frame length in bits minus one |
| rx_len_m1 | input | LEN_W | Receive frame length in bits minus one |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_tx_fs | input | 1 | External transmit frame clock (slave mode) |
| ext_rx_fs | input | 1 | External receive frame clock (slave mode) |
| bclk_out | output | 1 | Bit clock |
| tx_fs | output | 1 | Transmit frame clock |
| rx_fs | output | 1 | Receive frame clock |
| bit_lead_stb | output | 1 | Bit-start strobe |
| bit_trail_stb | output | 1 | Bit-middle strobe |

## Verification
In master mode, the bit clock, both frame clocks and both strobes change at the same clock edge. The bench therefore reads them together at the falling edge that follows. It takes frame-clock values only in cycles where the lead strobe is high.

In slave mode, the outputs trail the external inputs by two edges. The bench keeps a history of what it drove and compares each sample with the entry from two cycles earlier. In divider-field-0 mode, the bit clock is the master clock itself, so the bench samples one nanosecond into each half period.

For a divider or length change made mid-frame, the bench timestamps every lead strobe. It expects the old bit length for every bit up to the frame start and the new length from that point on.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int NUM_FRAMES = 2;
  localparam int CH_TX      = 0;
  localparam int CH_RX      = 1;

  // high-phase length for a ratio coded as value minus one
  function automatic int ceil_half(input int m1);
    return (m1 + 2) / 2;
  endfunction

  // first half of a frame, in bits, for a length coded as value minus one
  function automatic int floor_half(input int m1);
    return (m1 + 1) / 2;
  endfunction
endpackage

// File: rtl/clkgen_bitdiv.sv
module clkgen_bitdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_m1,
  input  logic             load,
  output logic             wrap,
  output logic             bclk_q,
  output logic             lead_q,
  output logic             trail_q,
  output logic             thru_q
);
  logic [DIV_W-1:0] act, cnt, act_n, cnt_n, hi;

  assign wrap = (cnt == act);

  always_comb begin
    act_n = load ? div_m1 : act;
    cnt_n = wrap ? '0 : cnt + 1'b1;
    hi    = DIV_W'(clkgen_pkg::ceil_half(int'(act_n)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= div_m1;
      cnt     <= div_m1;
      bclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      thru_q  <= 1'b0;
    end else begin
      act     <= act_n;
      cnt     <= cnt_n;
      bclk_q  <= (cnt_n < hi);
      lead_q  <= (cnt_n == '0);
      trail_q <= (act_n == '0) || (cnt_n == hi);
      thru_q  <= (act_n == '0);
    end
  end
endmodule

// File: rtl/clkgen_framediv.sv
module clkgen_framediv #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LEN_W-1:0] len_m1,
  output logic             boundary,
  output logic             fs_q
);
  logic [LEN_W-1:0] act, idx, act_n, idx_n, half;

  assign boundary = tick && (idx == act);

  always_comb begin
    act_n = boundary ? len_m1 : act;
    if (!tick)         idx_n = idx;
    else if (boundary) idx_n = '0;
    else               idx_n = idx + 1'b1;
    half = LEN_W'(clkgen_pkg::floor_half(int'(act_n)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= len_m1;
      idx  <= len_m1;
      fs_q <= 1'b0;
    end else begin
      act  <= act_n;
      idx  <= idx_n;
      fs_q <= (idx_n >= half);
    end
  end
endmodule

// File: rtl/clkgen_extsync.sv
module clkgen_extsync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] ext_in,
  output logic [2:0] sync_q,
  output logic       lead_q,
  output logic       trail_q
);
  logic [2:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      pipe[0] <= ext_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      lead_q  <= pipe[STAGES-2][0] & ~pipe[STAGES-1][0];
      trail_q <= ~pipe[STAGES-2][0] & pipe[STAGES-1][0];
    end
  end

  assign sync_q = pipe[STAGES-1];
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W       = 8,
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_sel,
  input  logic             bclk_inv,
  input  logic [DIV_W-1:0] bclk_div_m1,
  input  logic [LEN_W-1:0] tx_len_m1,
  input  logic [LEN_W-1:0] rx_len_m1,
  input  logic             ext_bclk,
  input  logic             ext_tx_fs,
  input  logic             ext_rx_fs,
  output logic             bclk_out,
  output logic             tx_fs,
  output logic             rx_fs,
  output logic             bit_lead_stb,
  output logic             bit_trail_stb
);
  import clkgen_pkg::*;

  localparam logic [NUM_FRAMES-1:0] TX_MASK = NUM_FRAMES'(1) << CH_TX;

  logic                  div_wrap, div_load;
  logic                  m_bclk, m_lead, m_trail, m_thru;
  logic [NUM_FRAMES-1:0] frame_bnd, fs_w;
  logic [2:0]            s_sync;
  logic                  s_lead, s_trail;
  logic                  slave_q, inv_q;

  assign div_load = |(frame_bnd & TX_MASK);

  clkgen_bitdiv #(.DIV_W(DIV_W)) u_bitdiv (
    .clk(clk), .rst(rst), .div_m1(bclk_div_m1), .load(div_load),
    .wrap(div_wrap), .bclk_q(m_bclk), .lead_q(m_lead),
    .trail_q(m_trail), .thru_q(m_thru)
  );

  for (genvar ch = 0; ch < NUM_FRAMES; ch++) begin : g_frame
    clkgen_framediv #(.LEN_W(LEN_W)) u_framediv (
      .clk(clk), .rst(rst), .tick(div_wrap),
      .len_m1((ch == CH_TX) ? tx_len_m1 : rx_len_m1),
      .boundary(frame_bnd[ch]), .fs_q(fs_w[ch])
    );
  end

  clkgen_extsync #(.STAGES(SYNC_STAGES)) u_extsync (
    .clk(clk), .rst(rst), .ext_in({ext_rx_fs, ext_tx_fs, ext_bclk}),
    .sync_q(s_sync), .lead_q(s_lead), .trail_q(s_trail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slave_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      slave_q <= slave_sel;
      inv_q   <= bclk_inv;
    end
  end

  assign bclk_out      = (slave_q ? s_sync[0] : (m_thru ? clk : m_bclk)) ^ inv_q;
  assign tx_fs         = slave_q ? s_sync[1] : fs_w[CH_TX];
  assign rx_fs         = slave_q ? s_sync[2] : fs_w[CH_RX];
  assign bit_lead_stb  = slave_q ? s_lead  : m_lead;
  assign bit_trail_stb = slave_q ? s_trail : m_trail;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic       clk,
  input logic       rst,
  input logic       m_bclk,
  input logic       m_lead,
  input logic       m_trail,
  input logic       m_thru,
  input logic [1:0] m_fs,
  input logic       s_bclk,
  input logic       s_lead
);
  // R3: lead strobe only while the generated clock is high
  assert_lead_in_high_R3: assert property (@(posedge clk) disable iff (rst)
    m_lead |-> m_bclk);

  // R2: each rising edge of the generated clock starts a bit
  assert_rise_has_lead_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(m_bclk) |-> m_lead);

  // R2: each falling edge is flagged as the bit middle
  assert_fall_has_trail_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(m_bclk) |-> m_trail);

  // R4: transmit frame clock moves only at a bit start
  assert_tx_fs_on_lead_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(m_fs[0]) |-> m_lead);

  // R5: receive frame clock moves only at a bit start
  assert_rx_fs_on_lead_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(m_fs[1]) |-> m_lead);

  // R8: pass-through ratio strobes both edges every cycle
  assert_thru_strobes_R8: assert property (@(posedge clk) disable iff (rst)
    m_thru |-> (m_lead && m_trail));

  // R7: external lead strobe coincides with a high synchronized clock
  assert_slave_lead_R7: assert property (@(posedge clk) disable iff (rst)
    s_lead |-> s_bclk);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk(clk), .rst(rst), .m_bclk(m_bclk), .m_lead(m_lead),
  .m_trail(m_trail), .m_thru(m_thru), .m_fs(fs_w),
  .s_bclk(s_sync[0]), .s_lead(s_lead)
);

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slave_sel = 1'b0, bclk_inv = 1'b0;
  logic [7:0] bclk_div_m1 = 8'd3, tx_len_m1 = 8'd63, rx_len_m1 = 8'd63;
  logic       ext_bclk = 1'b0, ext_tx_fs = 1'b0, ext_rx_fs = 1'b0;
  logic       bclk_out, tx_fs, rx_fs, bit_lead_stb, bit_trail_stb;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  audio_clkgen u_dut (
    .clk(clk), .rst(rst), .slave_sel(slave_sel), .bclk_inv(bclk_inv),
    .bclk_div_m1(bclk_div_m1), .tx_len_m1(tx_len_m1), .rx_len_m1(rx_len_m1),
    .ext_bclk(ext_bclk), .ext_tx_fs(ext_tx_fs), .ext_rx_fs(ext_rx_fs),
    .bclk_out(bclk_out), .tx_fs(tx_fs), .rx_fs(rx_fs),
    .bit_lead_stb(bit_lead_stb), .bit_trail_stb(bit_trail_stb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic slv, input logic inv, input int div,
                         input int tx, input int rx);
    slave_sel = slv; bclk_inv = inv;
    bclk_div_m1 = 8'(div); tx_len_m1 = 8'(tx); rx_len_m1 = 8'(rx);
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    set_cfg(0, 0, 3, 63, 63);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {bclk_out, tx_fs, rx_fs, bit_lead_stb, bit_trail_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first lead", bit_lead_stb, 1);
    chk("R1 first bclk", bclk_out, 1);
  endtask

  task automatic t_bitclk(input int div, input logic inv);
    int h = 0, l = 0, tr;
    set_cfg(0, inv, div, 63, 63);
    reset_dut();
    repeat (2) @(negedge clk);
    do @(negedge clk); while (!bit_lead_stb);
    while ((bclk_out ^ inv) == 1'b1) begin h++; @(negedge clk); end
    tr = bit_trail_stb;
    while ((bclk_out ^ inv) == 1'b0) begin l++; @(negedge clk); end
    chk($sformatf("R2 high len div=%0d", div), h, (div + 2) / 2);
    chk($sformatf("R2 low len div=%0d", div), l, (div + 1) / 2);
    chk("R3 trail at low start", tr, 1);
    chk("R3 lead at high start", bit_lead_stb, 1);
    chk("R6 bclk level at lead", bclk_out, inv ? 0 : 1);
  endtask

  task automatic t_frame(input int div, input int tx, input int rx);
    int etx = 0, erx = 0;
    set_cfg(0, 0, div, tx, rx);
    reset_dut();
    for (int b = 0; b < 2 * (tx + 1) + 2; b++) begin
      do @(negedge clk); while (!bit_lead_stb);
      if (tx_fs != ((b % (tx + 1)) >= (tx + 1) / 2)) etx++;
      if (rx_fs != ((b % (rx + 1)) >= (rx + 1) / 2)) erx++;
    end
    chk($sformatf("R4 tx frame errors tx=%0d", tx), etx, 0);
    chk($sformatf("R5 rx frame errors rx=%0d", rx), erx, 0);
  endtask

  task automatic t_change();
    int stamp [16];
    int cyc = 0, egap = 0, etx = 0, erx = 0;
    set_cfg(0, 0, 3, 7, 7);
    reset_dut();
    for (int b = 0; b < 16; b++) begin
      do begin @(negedge clk); cyc++; end while (!bit_lead_stb);
      stamp[b] = cyc;
      if (tx_fs != ((b < 8) ? (b >= 4) : (((b - 8) % 4) >= 2))) etx++;
      if (rx_fs != ((b < 8) ? (b >= 4) : (((b - 8) % 2) >= 1))) erx++;
      if (b >= 1 && (stamp[b] - stamp[b-1]) != ((b - 1 < 8) ? 4 : 2)) egap++;
      if (b == 3) begin bclk_div_m1 = 8'd1; tx_len_m1 = 8'd3; rx_len_m1 = 8'd1; end
    end
    chk("R9 bit length switches at frame start", egap, 0);
    chk("R9 tx length switches at frame start", etx, 0);
    chk("R9 rx length switches at frame start", erx, 0);
  endtask

  task automatic t_slave();
    logic [2:0] hist [64];
    int err = 0;
    set_cfg(1, 0, 3, 63, 63);
    {ext_rx_fs, ext_tx_fs, ext_bclk} = 3'b000;
    reset_dut();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        if (bclk_out != hist[k-2][0]) err++;
        if (tx_fs != hist[k-2][1]) err++;
        if (rx_fs != hist[k-2][2]) err++;
        if (bit_lead_stb != (hist[k-2][0] & ~hist[k-3][0])) err++;
        if (bit_trail_stb != (~hist[k-2][0] & hist[k-3][0])) err++;
      end
      hist[k] = {1'((k / 5) % 2), 1'((k / 8) % 2), 1'((k / 2) % 2)};
      {ext_rx_fs, ext_tx_fs, ext_bclk} = hist[k];
    end
    chk("R7 slave pass-through errors", err, 0);
  endtask

  task automatic t_thru(input logic inv);
    int err = 0;
    set_cfg(0, inv, 0, 63, 63);
    reset_dut();
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      if (bclk_out != ~inv) err++;
      if (!(bit_lead_stb && bit_trail_stb)) err++;
      @(negedge clk); #1;
      if (bclk_out != inv) err++;
    end
    chk($sformatf("R8 pass-through inv=%0d", inv), err, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bitclk(3, 0);
    t_bitclk(4, 0);
    t_bitclk(1, 0);
    t_bitclk(4, 1);
    t_frame(1, 63, 15);
    t_frame(3, 7, 14);
    t_frame(0, 9, 4);
    t_change();
    t_slave();
    t_thru(0);
    t_thru(1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule